// File: doc/BRIEF.md
# Cartridge bank and mirroring controller

This block sits on the 8-bit CPU bus of a game cartridge. It turns CPU writes into three small control registers and translates CPU and graphics-side addresses into ROM and RAM addresses. A switchable 8 KB page appears at $6000-$7FFF. The whole $8000-$FFFF range is pinned to the last four 8 KB pages of program ROM. The graphics side always sees its first 8 KB bank.

The block has two more outputs. One selects the nametable mirroring. The other is an enable line for a separate CPU-cycle interrupt timer, which clears and holds its own counter while that line is low. ROM contents are not stored here. The surrounding system, which is the testbench in this project, drives its memory from the translated addresses.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A CPU write to any address below $F000 leaves the page register, the mirroring select and the interrupt enable unchanged.
- R2: A write at $F000 or above picks its target from address bits [1:0]: 0 is the page register, 1 is mirroring and 2 is the interrupt enable. Code 3 changes nothing. Higher address bits are ignored, so $F004 acts as $F000 and $F006 or $F00A as $F002.
- R3: The page register takes all 8 data bits on a write. For CPU addresses $6000-$7FFF, `prg_addr_o` is {page, cpu_addr_i[12:0]} with the page field PRG_BANK_W bits wide.
- R4: For CPU addresses $8000-$FFFF, `prg_addr_o` is {PRG_BANKS-4+cpu_addr_i[14:13], cpu_addr_i[12:0]}. No write changes this mapping.
- R5: A write to the mirroring register with data bit 3 at 1 sets `mirror_h_o` to 1 (horizontal). With bit 3 at 0 it sets `mirror_h_o` to 0 (vertical). The other data bits are ignored.
- R6: `chr_addr_o` always equals `ppu_addr_i` (graphics bank 0). `chr_we_o` follows `ppu_we_i` when CHR_RAM is 1 and stays 0 when CHR_RAM is 0.
- R7: After reset the page is 0, `mirror_h_o` equals the MIRROR_DFLT_H parameter, and `irq_en_o` is 0.
- R8: A write to the interrupt register sets `irq_en_o` to data bit 1. The other data bits are ignored.
- R9: `prg_hit_o` is 1 exactly when the CPU address is $6000 or above. Below $6000, `prg_addr_o` is 0.
- R10: A page number of PRG_BANKS or more is reduced modulo PRG_BANKS. With 24 banks, 25 maps to page 1 and 255 maps to page 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe, sampled on the rising clock edge |
| ppu_addr_i | input | 13 | Graphics-side address |
| ppu_we_i | input | 1 | Graphics-side write strobe |
| prg_addr_o | output | PRG_BANK_W+13 | Translated program ROM address |
| prg_hit_o | output | 1 | CPU address lies in cartridge ROM space |
| chr_addr_o | output | 13 | Graphics memory address |
| chr_we_o | output | 1 | Graphics RAM write enable |
| mirror_h_o | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| irq_en_o | output | 1 | Enable for the external interrupt timer |

## Verification
A wrong page register, or a wrong modulo reduction, shows up as a wrong upper field in `prg_addr_o`. It is visible in the first probe of the $6000 window after the write, one clock edge later. A decode fault that hits the wrong register, or misses aliased addresses or the ignored code 3, shows the same way: the page field, `mirror_h_o` or `irq_en_o` takes a value it should not have on that same edge. An error in the fixed-region mapping appears combinationally on any probe above $8000, and the bench probes all four slots.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int unsigned CPU_AW  = 16;
  localparam int unsigned CPU_DW  = 8;
  localparam int unsigned WIN_W   = 13;
  localparam int unsigned MIR_BIT = 3;
  localparam int unsigned IRQ_BIT = 1;
  localparam logic [CPU_AW-1:0] REG_BASE = 16'hF000;
  localparam logic [CPU_AW-1:0] WIN_BASE = 16'h6000;

  typedef enum logic [1:0] {
    REG_PAGE = 2'd0,
    REG_MIR  = 2'd1,
    REG_IRQ  = 2'd2,
    REG_NONE = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/cart_reg_decode.sv
module cart_reg_decode
  import cart_pkg::*;
#(
  parameter bit MIRROR_DFLT_H = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_AW-1:0] addr_i,
  input  logic [CPU_DW-1:0] data_i,
  input  logic              we_i,
  output logic [CPU_DW-1:0] page_o,
  output logic              mirror_h_o,
  output logic              irq_en_o
);
  reg_idx_e idx;
  logic     sel;

  assign idx = reg_idx_e'(addr_i[1:0]);
  assign sel = we_i && (addr_i >= REG_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o     <= '0;
      mirror_h_o <= MIRROR_DFLT_H;
      irq_en_o   <= 1'b0;
    end else if (sel) begin
      unique case (idx)
        REG_PAGE: page_o     <= data_i;
        REG_MIR:  mirror_h_o <= data_i[MIR_BIT];
        REG_IRQ:  irq_en_o   <= data_i[IRQ_BIT];
        REG_NONE: ;
      endcase
    end
  end
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
  import cart_pkg::*;
#(
  parameter int unsigned PRG_BANKS  = 24,
  parameter int unsigned PRG_BANK_W = $clog2(PRG_BANKS)
) (
  input  logic [CPU_AW-1:0]         addr_i,
  input  logic [CPU_DW-1:0]         page_i,
  output logic [PRG_BANK_W+WIN_W-1:0] prg_addr_o,
  output logic                      hit_o
);
  logic [PRG_BANK_W-1:0] sw_bank;
  logic [PRG_BANK_W-1:0] fix_bank;

  // modulo keeps out-of-range page numbers inside the ROM
  assign sw_bank  = PRG_BANK_W'(32'(page_i) % PRG_BANKS);
  // $8000 slot 0..3 -> last four banks
  assign fix_bank = PRG_BANK_W'(PRG_BANKS - 4 + 32'(addr_i[14:13]));
  assign hit_o    = addr_i >= WIN_BASE;

  always_comb begin
    if (addr_i[15])
      prg_addr_o = {fix_bank, addr_i[WIN_W-1:0]};
    else if (hit_o)
      prg_addr_o = {sw_bank, addr_i[WIN_W-1:0]};
    else
      prg_addr_o = '0;
  end
endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map
  import cart_pkg::*;
#(
  parameter bit CHR_RAM = 1'b1
) (
  input  logic [WIN_W-1:0] ppu_addr_i,
  input  logic             ppu_we_i,
  output logic [WIN_W-1:0] chr_addr_o,
  output logic             chr_we_o
);
  assign chr_addr_o = ppu_addr_i;

  generate
    if (CHR_RAM) begin : g_ram
      assign chr_we_o = ppu_we_i;
    end else begin : g_rom
      logic unused_we;
      assign unused_we = ppu_we_i;
      assign chr_we_o  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_pkg::*;
#(
  parameter int unsigned PRG_BANKS     = 24,
  parameter bit          MIRROR_DFLT_H = 1'b0,
  parameter bit          CHR_RAM       = 1'b1,
  localparam int unsigned PRG_BANK_W   = $clog2(PRG_BANKS),
  localparam int unsigned PRG_AW       = PRG_BANK_W + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [CPU_DW-1:0] cpu_data_i,
  input  logic              cpu_we_i,
  input  logic [WIN_W-1:0]  ppu_addr_i,
  input  logic              ppu_we_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  output logic              prg_hit_o,
  output logic [WIN_W-1:0]  chr_addr_o,
  output logic              chr_we_o,
  output logic              mirror_h_o,
  output logic              irq_en_o
);
  logic [CPU_DW-1:0] page_q;

  cart_reg_decode #(.MIRROR_DFLT_H(MIRROR_DFLT_H)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (cpu_addr_i),
    .data_i     (cpu_data_i),
    .we_i       (cpu_we_i),
    .page_o     (page_q),
    .mirror_h_o (mirror_h_o),
    .irq_en_o   (irq_en_o)
  );

  cart_prg_map #(.PRG_BANKS(PRG_BANKS), .PRG_BANK_W(PRG_BANK_W)) u_prg (
    .addr_i     (cpu_addr_i),
    .page_i     (page_q),
    .prg_addr_o (prg_addr_o),
    .hit_o      (prg_hit_o)
  );

  cart_chr_map #(.CHR_RAM(CHR_RAM)) u_chr (
    .ppu_addr_i (ppu_addr_i),
    .ppu_we_i   (ppu_we_i),
    .chr_addr_o (chr_addr_o),
    .chr_we_o   (chr_we_o)
  );
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
  import cart_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 24,
  parameter bit          CHR_RAM   = 1'b1,
  localparam int unsigned PRG_BANK_W = $clog2(PRG_BANKS),
  localparam int unsigned PRG_AW     = PRG_BANK_W + WIN_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CPU_AW-1:0] cpu_addr_i,
  input logic [CPU_DW-1:0] cpu_data_i,
  input logic              cpu_we_i,
  input logic [WIN_W-1:0]  ppu_addr_i,
  input logic              ppu_we_i,
  input logic [PRG_AW-1:0] prg_addr_o,
  input logic              prg_hit_o,
  input logic [WIN_W-1:0]  chr_addr_o,
  input logic              chr_we_o,
  input logic              mirror_h_o,
  input logic              irq_en_o,
  input logic [CPU_DW-1:0] page_i
);
  assert_low_write_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i < REG_BASE) |=> ($stable(page_i) && $stable(mirror_h_o) && $stable(irq_en_o)));

  assert_code3_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i >= REG_BASE && cpu_addr_i[1:0] == 2'd3)
      |=> ($stable(page_i) && $stable(mirror_h_o) && $stable(irq_en_o)));

  assert_page_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i >= REG_BASE && cpu_addr_i[1:0] == 2'd0) |=> page_i == $past(cpu_data_i));

  assert_window_offset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] == 3'b011) |-> (prg_addr_o[WIN_W-1:0] == cpu_addr_i[WIN_W-1:0]
      && 32'(prg_addr_o[PRG_AW-1:WIN_W]) < PRG_BANKS));

  assert_last_bank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] == 3'b111) |-> (32'(prg_addr_o[PRG_AW-1:WIN_W]) == (PRG_BANKS - 1) % (2 ** PRG_BANK_W)));

  assert_mirror_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i >= REG_BASE && cpu_addr_i[1:0] == 2'd1) |=> mirror_h_o == $past(cpu_data_i[MIR_BIT]));

  assert_chr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_addr_o == ppu_addr_i) && (chr_we_o == (CHR_RAM && ppu_we_i)));

  assert_irq_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i >= REG_BASE && cpu_addr_i[1:0] == 2'd2) |=> irq_en_o == $past(cpu_data_i[IRQ_BIT]));

  assert_no_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i < WIN_BASE) |-> (!prg_hit_o && prg_addr_o == '0));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.PRG_BANKS(PRG_BANKS), .CHR_RAM(CHR_RAM)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_addr_i (cpu_addr_i),
  .cpu_data_i (cpu_data_i),
  .cpu_we_i   (cpu_we_i),
  .ppu_addr_i (ppu_addr_i),
  .ppu_we_i   (ppu_we_i),
  .prg_addr_o (prg_addr_o),
  .prg_hit_o  (prg_hit_o),
  .chr_addr_o (chr_addr_o),
  .chr_we_o   (chr_we_o),
  .mirror_h_o (mirror_h_o),
  .irq_en_o   (irq_en_o),
  .page_i     (page_q)
);

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;
  localparam int unsigned NB = 24;
  localparam int unsigned AW = 18;
  localparam int unsigned NV = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   cpu_addr_i = '0;
  logic [7:0]    cpu_data_i = '0;
  logic          cpu_we_i = 1'b0;
  logic [12:0]   ppu_addr_i = '0;
  logic          ppu_we_i = 1'b0;
  logic [AW-1:0] prg_addr_o;
  logic          prg_hit_o;
  logic [12:0]   chr_addr_o;
  logic          chr_we_o;
  logic          mirror_h_o;
  logic          irq_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  cart_bank_ctrl #(.PRG_BANKS(NB), .MIRROR_DFLT_H(1'b0), .CHR_RAM(1'b1)) dut (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_we_i, .ppu_addr_i, .ppu_we_i,
    .prg_addr_o, .prg_hit_o, .chr_addr_o, .chr_we_o, .mirror_h_o, .irq_en_o
  );

  // {wr_addr, wr_data, probe_addr, exp_prg_addr, exp_mirror, exp_irq}
  localparam logic [59:0] VEC [NV] = '{
    {16'hF000, 8'h05, 16'h6000, 18'h0A000, 1'b0, 1'b0}, // R3
    {16'hF004, 8'h07, 16'h7FFF, 18'h0FFFF, 1'b0, 1'b0}, // R2 alias page
    {16'hE000, 8'h09, 16'h6123, 18'h0E123, 1'b0, 1'b0}, // R1
    {16'hF001, 8'h08, 16'h8000, 18'h28000, 1'b1, 1'b0}, // R5 R4
    {16'hF002, 8'h02, 16'hA001, 18'h2A001, 1'b1, 1'b1}, // R8 R4
    {16'hF003, 8'hFF, 16'hC010, 18'h2C010, 1'b1, 1'b1}, // R2 code 3
    {16'hF005, 8'h00, 16'hFFFF, 18'h2FFFF, 1'b0, 1'b1}, // R2 R5 R4
    {16'hF006, 8'h00, 16'h6000, 18'h0E000, 1'b0, 1'b0}, // R2 R8
    {16'hF000, 8'h19, 16'h6004, 18'h02004, 1'b0, 1'b0}, // R10
    {16'hF000, 8'hFF, 16'h7000, 18'h1F000, 1'b0, 1'b0}, // R10
    {16'hEFFC, 8'h03, 16'h6000, 18'h1E000, 1'b0, 1'b0}, // R1
    {16'hF009, 8'h08, 16'h6000, 18'h1E000, 1'b1, 1'b0}, // R2 R5
    {16'hF001, 8'hF7, 16'h6000, 18'h1E000, 1'b0, 1'b0}, // R5
    {16'hF00A, 8'h02, 16'h6000, 18'h1E000, 1'b0, 1'b1}, // R2 R8
    {16'hF00A, 8'hFD, 16'h6000, 18'h1E000, 1'b0, 1'b0}, // R8
    {16'h7FFF, 8'hAA, 16'h8000, 18'h28000, 1'b0, 1'b0}  // R1 R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; cpu_we_i = 1'b1;
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a);
    cpu_addr_i = a;
    #1;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7 reset state
    probe(16'h6000);
    check("R7 page", 32'(prg_addr_o), 32'h0);
    check("R7 mirror", 32'(mirror_h_o), 32'h0);
    check("R7 irq", 32'(irq_en_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      cpu_write(VEC[i][59:44], VEC[i][43:36]);
      probe(VEC[i][35:20]);
      check($sformatf("vec%0d prg", i), 32'(prg_addr_o), 32'(VEC[i][19:2]));
      check($sformatf("vec%0d mirror", i), 32'(mirror_h_o), 32'(VEC[i][1]));
      check($sformatf("vec%0d irq", i), 32'(irq_en_o), 32'(VEC[i][0]));
    end

    // R4 all four fixed slots
    for (int s = 0; s < 4; s++) begin
      probe(16'h8000 + 16'(s) * 16'h2000 + 16'h0055);
      check("R4 slot", 32'(prg_addr_o), 32'(((NB - 4 + s) << 13) | 32'h55));
    end

    // R9 hit boundary
    probe(16'h5FFF);
    check("R9 miss hit", 32'(prg_hit_o), 32'h0);
    check("R9 miss addr", 32'(prg_addr_o), 32'h0);
    probe(16'h6000);
    check("R9 hit", 32'(prg_hit_o), 32'h1);

    // R6 graphics side
    ppu_addr_i = 13'h1ABC; ppu_we_i = 1'b1; #1;
    check("R6 addr", 32'(chr_addr_o), 32'h1ABC);
    check("R6 we", 32'(chr_we_o), 32'h1);
    ppu_we_i = 1'b0; #1;
    check("R6 we low", 32'(chr_we_o), 32'h0);

    // R7 reset mid-run
    cpu_write(16'hF000, 8'h03);
    cpu_write(16'hF001, 8'h08);
    cpu_write(16'hF002, 8'h02);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    probe(16'h6010);
    check("R7 page after reset", 32'(prg_addr_o), 32'h10);
    check("R7 mirror after reset", 32'(mirror_h_o), 32'h0);
    check("R7 irq after reset", 32'(irq_en_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule